// File: doc/BRIEF.md
# Printer port register interface

This block sits on a host's simple synchronous register bus and drives a legacy 25-pin printer connector. Software sees three byte-wide registers: one holding the outgoing data byte, one read-only view of the printer's handshake and fault inputs, and one that drives the handshake outputs and selects the port's operating options. Each handshake line crosses between its register bit and its pin with a fixed polarity. Some lines are inverted and some pass straight through, so the block does that mapping and software never has to.

The eight data lines can be turned around. When the direction bit is set, the data drivers are released. The output latch keeps whatever is written to it, but nothing is driven onto the pins. A read of the data offset always shows the pins themselves, so in that mode it returns what the far device is driving. Every pin input passes through a two-stage synchroniser before the bus or the interrupt logic can use it. With the interrupt enabled, a falling edge on the acknowledge line raises a sticky interrupt request, and a read of the status register clears it.

Bus reads are combinational. `bus_rdata` is valid in the same cycle as `bus_rd`. A write takes effect at the clock edge on which `bus_wr` is high.

Top module: `pport_regs`

## Requirements
- R1: After reset, the data latch is 0x00 and the control register reads 0x00. The pins then sit as follows: strobe, auto-feed and select-in are high, initialise is low, the data drivers are enabled (`dpin_oe` = 1) and `irq` is 0.
- R2: A write to offset 0 drives the written byte on `dpin_out` from the next cycle. The byte is held there through writes to any other offset.
- R3: A read of offset 0 returns the eight data pins (`dpin_in`) as seen after a two-flop synchroniser, and never the latch contents.
- R4: A read of offset 1 returns {not Busy, Ack, Paper-out, Select, Error, 3'b111} in bit order 7 down to 0, with the pin levels taken after a two-flop synchroniser.
- R5: A write to offset 1 changes nothing: the data latch, the control register, the pins and the status reading are all unaffected.
- R6: Control bits 0 (strobe), 1 (auto-feed) and 3 (select-in) drive their pins inverted, so writing 1 drives the pin low. Bit 2 (initialise) drives its pin with true polarity.
- R7: A read of offset 2 returns control bits 5 to 0 as last written. Bits 7 and 6 are ignored on write and read as 0.
- R8: Control bit 5 set to 1 drives `dpin_oe` to 0. Data writes made in that state are stored and appear on `dpin_out`, and they are driven again once bit 5 is cleared.
- R9: When control bit 4 is 1, a falling edge on the synchronised Ack input sets `irq`, and `irq` stays set after Ack rises again. When bit 4 is 0, an Ack falling edge does not set `irq`.
- R10: A read of offset 1 clears `irq` at the end of that read cycle.
- R11: Offset 3 reads as 0x00, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid while bus_rd is high |
| irq | output | 1 | Sticky acknowledge interrupt request |
| dpin_in | input | 8 | Levels sensed on the data pins |
| dpin_out | output | 8 | Output data latch toward the data pins |
| dpin_oe | output | 1 | Data pin driver enable, 1 = driving |
| pin_strobe_o | output | 1 | Strobe pin level |
| pin_autofd_o | output | 1 | Auto-feed pin level |
| pin_init_o | output | 1 | Initialise pin level |
| pin_selin_o | output | 1 | Select-in pin level |
| pin_busy_i | input | 1 | Busy pin level |
| pin_ack_i | input | 1 | Acknowledge pin level |
| pin_paper_i | input | 1 | Paper-out pin level |
| pin_sel_i | input | 1 | Select pin level |
| pin_err_i | input | 1 | Error pin level |

## Verification
The bench models the connector as a wire: the pins follow `dpin_out` while the drivers are enabled and an external byte otherwise. That lets it catch a design that reads the latch instead of the pins, which would return the written byte rather than the external one when the port is turned around. It also writes data while the drivers are released and then re-enables them, so a design that dropped such writes, or blocked them, would show the stale byte. Two opposite status patterns catch a missing or misplaced Busy inversion and a wrong fill of the low bits. Writes to the read-only and spare offsets, followed by readback of the data and control registers, expose any decode that lets them through. The interrupt is exercised with the enable set and clear. After Ack rises again the bench checks that `irq` is still set, then checks that a status read clears it, so a level-sensitive or non-sticky request is seen.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int CTRL_W   = 6;
  localparam int NUM_STAT = 5;

  localparam logic [ADDR_W-1:0] OFS_DATA  = 2'd0;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 2'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL  = 2'd2;
  localparam logic [ADDR_W-1:0] OFS_SPARE = 2'd3;

  // Control bit positions (software visible, fixed by behaviour)
  localparam int CB_STB  = 0;
  localparam int CB_AFD  = 1;
  localparam int CB_INIT = 2;
  localparam int CB_SELI = 3;
  localparam int CB_IEN  = 4;
  localparam int CB_DIR  = 5;

  // Order of status inputs inside the synchroniser vector
  localparam int SI_ERR   = 0;
  localparam int SI_SEL   = 1;
  localparam int SI_PAPER = 2;
  localparam int SI_ACK   = 3;
  localparam int SI_BUSY  = 4;

  localparam logic [2:0] STAT_FILL = 3'b111;
endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[i] <= '0;
      else        stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_we,
  input  logic              ctrl_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] latch_q,
  output logic [CTRL_W-1:0] ctrl_q
);
  logic [BYTE_W-1:0] latch_d;
  logic [CTRL_W-1:0] ctrl_d;

  always_comb begin
    latch_d = latch_q;
    ctrl_d  = ctrl_q;
    if (data_we) latch_d = wdata;
    if (ctrl_we) ctrl_d  = wdata[CTRL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
      ctrl_q  <= '0;
    end else begin
      if (data_we) latch_q <= latch_d;
      if (ctrl_we) ctrl_q  <= ctrl_d;
    end
  end
endmodule

// File: rtl/pport_irq.sv
module pport_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic enable,
  input  logic clear,
  output logic pend_q
);
  logic ack_d_q;
  logic fall;
  logic pend_d;

  always_comb begin
    fall   = ack_d_q & ~ack_s;
    // a new edge in the clearing cycle wins so no event is lost
    pend_d = (enable & fall) | (pend_q & ~clear);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      ack_d_q <= ack_s;
      pend_q  <= pend_d;
    end
  end
endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq,
  input  logic [BYTE_W-1:0] dpin_in,
  output logic [BYTE_W-1:0] dpin_out,
  output logic              dpin_oe,
  output logic              pin_strobe_o,
  output logic              pin_autofd_o,
  output logic              pin_init_o,
  output logic              pin_selin_o,
  input  logic              pin_busy_i,
  input  logic              pin_ack_i,
  input  logic              pin_paper_i,
  input  logic              pin_sel_i,
  input  logic              pin_err_i
);
  localparam int SYNC_W = BYTE_W + NUM_STAT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign srst_n = rst_pipe_q[1];

  // input synchronisers
  logic [NUM_STAT-1:0] stat_raw;
  logic [SYNC_W-1:0]   sync_d;
  logic [SYNC_W-1:0]   sync_q;
  logic [NUM_STAT-1:0] stat_s;
  logic [BYTE_W-1:0]   dpin_s;

  always_comb begin
    stat_raw           = '0;
    stat_raw[SI_ERR]   = pin_err_i;
    stat_raw[SI_SEL]   = pin_sel_i;
    stat_raw[SI_PAPER] = pin_paper_i;
    stat_raw[SI_ACK]   = pin_ack_i;
    stat_raw[SI_BUSY]  = pin_busy_i;
  end

  assign sync_d = {stat_raw, dpin_in};

  pport_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (srst_n),
    .d     (sync_d),
    .q     (sync_q)
  );

  assign dpin_s = sync_q[BYTE_W-1:0];
  assign stat_s = sync_q[SYNC_W-1:BYTE_W];

  // register decode
  logic data_we;
  logic ctrl_we;
  logic stat_rd;

  assign data_we = bus_wr && (bus_addr == OFS_DATA);
  assign ctrl_we = bus_wr && (bus_addr == OFS_CTRL);
  assign stat_rd = bus_rd && (bus_addr == OFS_STAT);

  logic [BYTE_W-1:0] latch_q;
  logic [CTRL_W-1:0] ctrl_q;

  pport_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (srst_n),
    .data_we (data_we),
    .ctrl_we (ctrl_we),
    .wdata   (bus_wdata),
    .latch_q (latch_q),
    .ctrl_q  (ctrl_q)
  );

  pport_irq u_irq (
    .clk    (clk),
    .rst_n  (srst_n),
    .ack_s  (stat_s[SI_ACK]),
    .enable (ctrl_q[CB_IEN]),
    .clear  (stat_rd),
    .pend_q (irq)
  );

  // pin polarity mapping
  assign dpin_out     = latch_q;
  assign dpin_oe      = ~ctrl_q[CB_DIR];
  assign pin_strobe_o = ~ctrl_q[CB_STB];
  assign pin_autofd_o = ~ctrl_q[CB_AFD];
  assign pin_init_o   =  ctrl_q[CB_INIT];
  assign pin_selin_o  = ~ctrl_q[CB_SELI];

  // read mux
  logic [BYTE_W-1:0] stat_word;

  assign stat_word = {~stat_s[SI_BUSY], stat_s[SI_ACK], stat_s[SI_PAPER],
                      stat_s[SI_SEL], stat_s[SI_ERR], STAT_FILL};

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_DATA: bus_rdata = dpin_s;
        OFS_STAT: bus_rdata = stat_word;
        OFS_CTRL: bus_rdata = {{(BYTE_W-CTRL_W){1'b0}}, ctrl_q};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/pport_regs_chk.sv
module pport_regs_chk (
  input logic       clk,
  input logic       srst_n,
  input logic [1:0] bus_addr,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic [7:0] dpin_out,
  input logic       dpin_oe,
  input logic       pin_strobe_o,
  input logic       pin_init_o,
  input logic       irq_en
);
  assert_data_latch_R2: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == 2'd0) |=> dpin_out == $past(bus_wdata));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!srst_n)
    !(bus_wr && bus_addr == 2'd0) |=> $stable(dpin_out));

  assert_ctrl_polarity_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == 2'd2) |=>
      (pin_strobe_o == !$past(bus_wdata[0])) && (pin_init_o == $past(bus_wdata[2])));

  assert_ctrl_upper_zero_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_rd && bus_addr == 2'd2) |-> bus_rdata[7:6] == 2'b00);

  assert_dir_release_R8: assert property (@(posedge clk) disable iff (!srst_n)
    (bus_wr && bus_addr == 2'd2) |=> dpin_oe == !$past(bus_wdata[5]));

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (!srst_n)
    $rose(irq) |-> $past(irq_en));
endmodule

bind pport_regs pport_regs_chk u_chk (
  .clk          (clk),
  .srst_n       (srst_n),
  .bus_addr     (bus_addr),
  .bus_wr       (bus_wr),
  .bus_rd       (bus_rd),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .irq          (irq),
  .dpin_out     (dpin_out),
  .dpin_oe      (dpin_oe),
  .pin_strobe_o (pin_strobe_o),
  .pin_init_o   (pin_init_o),
  .irq_en       (ctrl_q[4])
);

// File: tb/pport_regs_tb.sv
module pport_regs_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [7:0] dpin_in;
  logic [7:0] dpin_out;
  logic       dpin_oe;
  logic       pin_strobe_o, pin_autofd_o, pin_init_o, pin_selin_o;
  logic       pin_busy_i = 1'b1, pin_ack_i = 1'b1, pin_paper_i = 1'b0;
  logic       pin_sel_i = 1'b1, pin_err_i = 1'b0;
  logic [7:0] ext_drv = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  // connector model: pins follow the latch while driven
  assign dpin_in = dpin_oe ? dpin_out : ext_drv;

  pport_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .dpin_in(dpin_in), .dpin_out(dpin_out), .dpin_oe(dpin_oe),
    .pin_strobe_o(pin_strobe_o), .pin_autofd_o(pin_autofd_o),
    .pin_init_o(pin_init_o), .pin_selin_o(pin_selin_o),
    .pin_busy_i(pin_busy_i), .pin_ack_i(pin_ack_i), .pin_paper_i(pin_paper_i),
    .pin_sel_i(pin_sel_i), .pin_err_i(pin_err_i)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] r;
    rst_n = 1'b0;
    wait_clks(3);
    rst_n = 1'b1;
    wait_clks(4);
    check("R1 latch", dpin_out, 8'h00);
    bus_read(2'd2, r);
    check("R1 ctrl", r, 8'h00);
    check("R1 pins", {3'b000, pin_strobe_o, pin_autofd_o, pin_init_o, pin_selin_o, dpin_oe},
          8'b0001_1011);
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_data_path();
    logic [7:0] r;
    bus_write(2'd0, 8'hA5);
    check("R2 drive", dpin_out, 8'hA5);
    bus_write(2'd2, 8'h00);
    check("R2 hold", dpin_out, 8'hA5);
    wait_clks(3);
    bus_read(2'd0, r);
    check("R3 driven readback", r, 8'hA5);
    bus_write(2'd2, 8'h20);
    check("R8 oe off", {7'd0, dpin_oe}, 8'h00);
    ext_drv = 8'h3C;
    wait_clks(3);
    bus_read(2'd0, r);
    check("R3 external", r, 8'h3C);
    bus_write(2'd0, 8'h99);
    check("R8 stored", dpin_out, 8'h99);
    wait_clks(3);
    bus_read(2'd0, r);
    check("R3 pins not latch", r, 8'h3C);
    bus_write(2'd2, 8'h00);
    check("R8 oe on", {7'd0, dpin_oe}, 8'h01);
    wait_clks(3);
    bus_read(2'd0, r);
    check("R8 redriven", r, 8'h99);
  endtask

  task automatic t_status();
    logic [7:0] r;
    pin_busy_i = 1; pin_ack_i = 1; pin_paper_i = 0; pin_sel_i = 1; pin_err_i = 0;
    wait_clks(3);
    bus_read(2'd1, r);
    check("R4 pattern a", r, 8'h57);
    pin_busy_i = 0; pin_ack_i = 0; pin_paper_i = 1; pin_sel_i = 0; pin_err_i = 1;
    wait_clks(3);
    bus_read(2'd1, r);
    check("R4 pattern b", r, 8'hAF);
    pin_ack_i = 1;
    wait_clks(3);
    check("R9 no irq when off", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ignored_writes();
    logic [7:0] r;
    bus_write(2'd2, 8'h05);
    bus_write(2'd1, 8'hFF);
    check("R5 latch", dpin_out, 8'h99);
    bus_read(2'd2, r);
    check("R5 ctrl", r, 8'h05);
    bus_read(2'd1, r);
    check("R5 status", r, 8'hEF);
    bus_write(2'd3, 8'h77);
    bus_read(2'd3, r);
    check("R11 spare read", r, 8'h00);
    check("R11 latch", dpin_out, 8'h99);
    bus_read(2'd2, r);
    check("R11 ctrl", r, 8'h05);
    bus_write(2'd2, 8'h00);
  endtask

  task automatic t_control();
    logic [7:0] r;
    bus_write(2'd2, 8'h0F);
    check("R6 pins 0F", {4'd0, pin_strobe_o, pin_autofd_o, pin_init_o, pin_selin_o}, 8'h02);
    bus_write(2'd2, 8'hC5);
    bus_read(2'd2, r);
    check("R7 readback", r, 8'h05);
    check("R6 pins 05", {4'd0, pin_strobe_o, pin_autofd_o, pin_init_o, pin_selin_o}, 8'h07);
    bus_write(2'd2, 8'h00);
    check("R6 pins 00", {4'd0, pin_strobe_o, pin_autofd_o, pin_init_o, pin_selin_o}, 8'h0D);
  endtask

  task automatic t_irq();
    logic [7:0] r;
    bus_write(2'd2, 8'h10);
    pin_ack_i = 1'b0;
    wait_clks(4);
    check("R9 set", {7'd0, irq}, 8'h01);
    pin_ack_i = 1'b1;
    wait_clks(4);
    check("R9 sticky", {7'd0, irq}, 8'h01);
    bus_read(2'd1, r);
    check("R10 cleared", {7'd0, irq}, 8'h00);
    bus_write(2'd2, 8'h00);
    pin_ack_i = 1'b0;
    wait_clks(4);
    check("R9 disabled", {7'd0, irq}, 8'h00);
    pin_ack_i = 1'b1;
    wait_clks(3);
  endtask

  initial begin
    t_reset();
    t_data_path();
    t_status();
    t_ignored_writes();
    t_control();
    t_irq();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule